// File: doc/BRIEF.md
# Per-Peripheral Clock Rate Divider

This block derives a slower operating rate for a single on-chip peripheral from the base clock. It does not produce a new clock. It produces a one-cycle enable pulse, `tick`, at the selected rate, and the peripheral qualifies its own flops with that pulse. A 3-bit ratio code picks one of six ratios: 1, 2, 3, 5, 8 or 64. Two code values are reserved.

Software writes the code through a single-cycle write strobe. A reserved code is refused and flagged. An accepted code does not take effect at once: it is held as pending and loaded at the end of the current division period, so no period is ever cut short.

The reset value of the code depends on a static clock-mode strap. The block also provides a registered divided level for observation, and a readback of the ratio code that is in effect.

Top module: `clkdiv_unit`

## Requirements
- R1: With code 000 in effect, `tick` is high on every base-clock cycle.
- R2: Codes 001, 010 and 011 make the period between `tick` pulses 2, 3 and 5 cycles. Each pulse is one cycle wide.
- R3: Codes 110 and 111 make the period 8 and 64 cycles respectively.
- R4: A write of code 100 or 101 is ignored, and the ratio in effect and `sel_rd` keep their previous value.
- R5: `cfg_err` is high for exactly the one cycle that follows the clock edge that samples a reserved-code write. It is low otherwise.
- R6: While reset is applied and after it, the code in effect is 000 when `clk_mode` is 1, 3, 5 or 6, and 111 when `clk_mode` is 0, 2, 4 or 7.
- R7: An accepted code takes effect only after the current period has completed. The period in progress at the write keeps its full old length.
- R8: There is exactly one `tick` per period. The counter never exceeds the last count of the ratio in effect.
- R9: `sel_rd` shows the code in effect, not a pending one.
- R10: `div_lvl` is high for the first ceil(N/2) cycles of each period and low for the rest. For ratio 5, the five cycles of a period read 1,1,1,0,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_mode | input | 3 | Static clock-mode strap selecting the reset code |
| wr_en | input | 1 | Write strobe for the ratio code |
| wr_data | input | 3 | Ratio code to write |
| sel_rd | output | 3 | Ratio code in effect |
| cfg_err | output | 1 | One-cycle flag for a refused reserved-code write |
| tick | output | 1 | One-cycle enable at the divided rate |
| div_lvl | output | 1 | Registered divided level for observation |

## Verification
The bench uses the default two-stage reset synchronizer and the full ratio set. Because the longest period is only 64 cycles, every ratio, every reserved code and a mid-period change away from the slowest ratio can each be measured over whole periods in a short run. Two separate resets with different `clk_mode` values cover both reset codes. The counter width derived from the largest ratio is exercised all the way to its top count.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned MODE_W    = 3;
  localparam int unsigned MAX_RATIO = 64;
  localparam int unsigned CNT_W     = $clog2(MAX_RATIO);

  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  function automatic logic code_ok(sel_t c);
    return (c != 3'b100) && (c != 3'b101);
  endfunction

  // last counter value of a period: ratio - 1
  function automatic cnt_t last_count(sel_t c);
    case (c)
      3'b001:  return cnt_t'(1);
      3'b010:  return cnt_t'(2);
      3'b011:  return cnt_t'(4);
      3'b110:  return cnt_t'(7);
      3'b111:  return cnt_t'(MAX_RATIO - 1);
      default: return cnt_t'(0);
    endcase
  endfunction

  // number of cycles the observed level stays high: ceil(ratio/2)
  function automatic cnt_t high_len(sel_t c);
    return cnt_t'((int'(last_count(c)) + 2) / 2);
  endfunction

  function automatic sel_t boot_code(mode_t m);
    case (m)
      3'd1, 3'd3, 3'd5, 3'd6: return 3'b000;
      default:                return 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/clkdiv_cfg.sv
module clkdiv_cfg
  import clkdiv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t clk_mode,
  input  logic  wr_en,
  input  sel_t  wr_data,
  input  logic  boundary,
  output sel_t  active_q,
  output sel_t  active_d,
  output logic  err_q
);
  sel_t pend_q, pend_d;
  logic err_d;
  logic accept;

  always_comb begin
    accept   = wr_en && code_ok(wr_data);
    err_d    = wr_en && !code_ok(wr_data);
    pend_d   = accept ? wr_data : pend_q;
    active_d = boundary ? pend_q : active_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= boot_code(clk_mode);
      active_q <= boot_code(clk_mode);
      err_q    <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      active_q <= active_d;
      err_q    <= err_d;
    end
  end

  // R4: a reserved code never becomes the active ratio
  a_r4_active_valid: assert property (@(posedge clk) disable iff (!rst_n)
    code_ok(active_q));
  // R5: the flag is raised only by a refused write one edge earlier
  a_r5_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(wr_en && !code_ok(wr_data)));
  // R7: the active ratio changes only right after a period boundary
  a_r7_change_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q != $past(active_q)) |-> $past(boundary));
endmodule

// File: rtl/clkdiv_count.sv
module clkdiv_count
  import clkdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sel_t active_q,
  input  sel_t active_d,
  output logic tick,
  output logic lvl_q
);
  cnt_t cnt_q, cnt_d;
  logic lvl_d;

  always_comb begin
    tick  = (cnt_q == last_count(active_q));
    cnt_d = tick ? '0 : cnt_q + cnt_t'(1);
    lvl_d = (cnt_d < high_len(active_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  // R8: the counter stays inside the active period
  a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_count(active_q));
  // R1: undivided setting keeps the enable high
  a_r1_undivided: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q == 3'b000) |-> tick);
  // R10: every period starts with the level high
  a_r10_level_start: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> lvl_q);
endmodule

// File: rtl/clkdiv_unit.sv
module clkdiv_unit
  import clkdiv_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_mode,
  input  logic       wr_en,
  input  logic [2:0] wr_data,
  output logic [2:0] sel_rd,
  output logic       cfg_err,
  output logic       tick,
  output logic       div_lvl
);
  logic srst_n;
  sel_t act_q, act_d;

  clkdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  clkdiv_cfg u_cfg (
    .clk(clk), .rst_n(srst_n), .clk_mode(clk_mode), .wr_en(wr_en),
    .wr_data(wr_data), .boundary(tick), .active_q(act_q),
    .active_d(act_d), .err_q(cfg_err));

  clkdiv_count u_cnt (
    .clk(clk), .rst_n(srst_n), .active_q(act_q), .active_d(act_d),
    .tick(tick), .lvl_q(div_lvl));

  assign sel_rd = act_q;

  // R9: readback follows only accepted codes
  a_r9_readback_valid: assert property (@(posedge clk) disable iff (!srst_n)
    (sel_rd != $past(sel_rd)) |-> code_ok(sel_rd));
endmodule

// File: tb/clkdiv_unit_test.sv
module clkdiv_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] clk_mode;
  logic       wr_en;
  logic [2:0] wr_data;
  logic [2:0] sel_rd;
  logic       cfg_err, tick, div_lvl;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clkdiv_unit uut (
    .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode), .wr_en(wr_en),
    .wr_data(wr_data), .sel_rd(sel_rd), .cfg_err(cfg_err),
    .tick(tick), .div_lvl(div_lvl));

  // {code, expected period, expect refusal}
  localparam logic [11:0] VEC [9] = '{
    {3'b001, 8'd2,  1'b0}, {3'b010, 8'd3,  1'b0}, {3'b100, 8'd3,  1'b1},
    {3'b011, 8'd5,  1'b0}, {3'b110, 8'd8,  1'b0}, {3'b101, 8'd8,  1'b1},
    {3'b111, 8'd64, 1'b0}, {3'b000, 8'd1,  1'b0}, {3'b011, 8'd5,  1'b0}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] mode);
    clk_mode = mode; wr_en = 0; wr_data = '0; rst_n = 0;
    repeat (3) @(negedge clk);
    check(sel_rd == ((mode inside {1,3,5,6}) ? 3'b000 : 3'b111), "R6 in reset",
          sel_rd, (mode inside {1,3,5,6}) ? 0 : 7);
    check(cfg_err == 0, "R5 reset", cfg_err, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic write(input logic [2:0] c);
    @(negedge clk); wr_en = 1; wr_data = c;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic next_tick(output int cyc);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!tick && cyc < 300);
  endtask

  task automatic period(output int p);
    int dummy;
    next_tick(dummy);
    next_tick(p);
  endtask

  initial begin
    int p, w;
    logic [2:0] prev;
    do_reset(3'd0);
    check(sel_rd == 3'b111, "R6 mode0", sel_rd, 7);
    period(p);
    check(p == 64, "R3 boot ratio 64", p, 64);

    prev = 3'b111;
    foreach (VEC[i]) begin
      logic [2:0] c;
      int exp_p;
      c = VEC[i][11:9]; exp_p = int'(VEC[i][8:1]);
      write(c);
      if (VEC[i][0]) begin
        check(cfg_err == 1, "R5 flag raised", cfg_err, 1);
        @(negedge clk);
        check(cfg_err == 0, "R5 flag one cycle", cfg_err, 0);
        check(sel_rd == prev, "R4 code kept", sel_rd, prev);
      end else begin
        check(cfg_err == 0, "R5 no flag on valid", cfg_err, 0);
        w = 0;
        while (sel_rd != c && w < 200) begin @(negedge clk); w++; end
        check(sel_rd == c, "R9 readback", sel_rd, c);
        prev = c;
      end
      period(p);
      check(p == exp_p, (c inside {1,2,3}) ? "R2 period" :
            (c == 0) ? "R1 period" : (VEC[i][0] ? "R4 period" : "R3 period"),
            p, exp_p);
    end

    // R10: level pattern over one ratio-5 period
    next_tick(p);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(div_lvl == (k < 3), "R10 level", div_lvl, k < 3);
      check(tick == (k == 4), "R8 single tick", tick, k == 4);
    end

    // R7: change requested mid-period of ratio 64
    write(3'b111);
    while (sel_rd != 3'b111) @(negedge clk);
    next_tick(p);
    repeat (10) @(negedge clk);
    write(3'b001);
    check(sel_rd == 3'b111, "R9 pending not shown", sel_rd, 7);
    p = 12;
    while (!tick && p < 300) begin @(negedge clk); p++; end
    check(p == 64, "R7 full old period", p, 64);
    next_tick(p);
    check(p == 2, "R7 new ratio next", p, 2);
    check(sel_rd == 3'b001, "R9 after boundary", sel_rd, 1);

    // R6 and R1: other clock mode
    do_reset(3'd6);
    check(sel_rd == 3'b000, "R6 mode6", sel_rd, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(tick == 1, "R1 continuous", tick, 1);
    end
    do_reset(3'd4);
    check(sel_rd == 3'b111, "R6 mode4", sel_rd, 7);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule